// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. It samples eight request wires every clock and records them in a request register. Each line is either edge-sensitive or level-sensitive, as set by a trigger-mode register. It holds an in-service register and a 3-bit rotation base. From this registered state it works out, without extra pipeline stages, whether the processor should be interrupted and which line would win.

A register block outside this core supplies the mask, the mode enables and writes to the trigger-mode register. It also issues end-of-interrupt commands. The processor side raises an acknowledge strobe. In the cycle of that strobe, the core reports the winning line and records it as in service. Address decoding and chaining of several controllers belong to other blocks.

Top module: `irq_core`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level) has its request bit copy the input sampled at each clock edge: 1 while the input is high, 0 while it is low.
- R2: A line whose trigger-mode bit is 0 (edge) sets its request bit only at an edge where the input is high and was low at the previous edge. A low input does not clear a set request bit; only an acknowledge of that line does.
- R3: The priority search begins at the line equal to the rotation base and wraps modulo 8, so the base line has the highest priority. The base is 0 after reset.
- R4: `irq_out` is 1 only when the best unmasked pending line (request bit 1, `mask_in` bit 0) ranks strictly above the best in-service line, or when nothing is in service. `irq_line` then names that line.
- R5: When `IS_MASTER` is set and `nest_en` is 1, the in-service bit of line `CASC_LINE` (2) is left out of the in-service ranking.
- R6: An acknowledge while a winner exists sets that line's in-service bit. It clears the line's request bit only if the line is edge-sensitive. `ack_line` gives the winner; with no winner, `ack_none` is 1, `ack_line` is 7 and no state changes.
- R7: With `auto_eoi_en` at 1, an acknowledge leaves the in-service bit clear. If `auto_rot_en` is also 1, the rotation base becomes (winner+1) mod 8.
- R8: An end-of-interrupt command (`eoi_valid`) uses `eoi_kind` bit 0 = specific and bit 1 = rotate. A non-specific command clears the highest-ranked in-service bit under the current base. A specific command clears in-service bit `eoi_line`. With rotate set, the base becomes (cleared line+1) mod 8. A non-specific command with nothing in service does nothing.
- R9: A write to the trigger-mode register stores `trig_wdata` ANDed with 0xF8 when `IS_MASTER` is 1, or with 0xDE otherwise. The new modes take effect from the following edge.
- R10: When an end-of-interrupt command and an acknowledge arrive in the same cycle, the command is applied first. The winner and `ack_line` are computed from the in-service bits and base after the command.
- R11: After reset, the request, last-level and in-service registers are 0, the base is 0, all lines are edge-sensitive and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 8 | Interrupt request wires |
| mask_in | input | 8 | Mask bits, 1 blocks the line from resolution |
| trig_wr | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | 8 | Trigger-mode write data, 1 = level |
| nest_en | input | 1 | Leave the cascade line out of in-service ranking |
| auto_eoi_en | input | 1 | Automatic end of interrupt at acknowledge |
| auto_rot_en | input | 1 | Rotate the base on automatic end of interrupt |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_kind | input | 2 | Bit 0 specific, bit 1 rotate |
| eoi_line | input | 3 | Target line of a specific command |
| ack_req | input | 1 | Acknowledge strobe |
| irq_out | output | 1 | Interrupt request toward the processor |
| irq_line | output | 3 | Line behind `irq_out` |
| ack_line | output | 3 | Line an acknowledge in this cycle takes, 7 if none |
| ack_none | output | 1 | No winner for an acknowledge in this cycle |
| irr_out | output | 8 | Request register |
| isr_out | output | 8 | In-service register |

## Verification
A wrong request or in-service bit appears on `irr_out` or `isr_out` one edge after the stimulus that caused it. A stale rotation base has no port of its own. It shows only later, when two lines compete and `irq_line` or `ack_line` names the wrong one, which may be many cycles on. For that reason the bench compares every output against a reference model in every cycle. The directed cases are set up so that a wrong base, a skipped cascade exclusion or a wrong EOI/acknowledge order changes the winner within one or two cycles.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
    localparam int unsigned LINES = 8;
    localparam int unsigned LW    = $clog2(LINES);

    localparam int unsigned EOI_SPEC_BIT = 0;
    localparam int unsigned EOI_ROT_BIT  = 1;

    typedef logic [LINES-1:0] vec_t;
    typedef logic [LW-1:0]    line_t;

    typedef struct packed {
        vec_t irr;
        vec_t last;
    } cap_state_t;

    typedef struct packed {
        vec_t  isr;
        line_t base;
        vec_t  trig;
    } core_state_t;
endpackage

// File: rtl/irq_rot_find.sv
module irq_rot_find
    import irq_core_pkg::*;
(
    input  vec_t  bits,
    input  line_t base,
    output logic  found,
    output line_t line
);
    vec_t  rot;
    line_t rank;

    always_comb begin
        rot   = (bits >> base) | (bits << (LINES - base));
        found = |rot;
        rank  = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            if (rot[k]) rank = line_t'(k);
        end
        line = base + rank;
    end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_core_pkg::*;
(
    input  vec_t  pend,
    input  vec_t  isr,
    input  vec_t  isr_ignore,
    input  line_t base,
    output logic  hit,
    output line_t line
);
    logic  p_found, s_found;
    line_t p_line, s_line, p_rank, s_rank;
    vec_t  isr_rank;

    assign isr_rank = isr & ~isr_ignore;

    irq_rot_find u_pend (.bits(pend),     .base(base), .found(p_found), .line(p_line));
    irq_rot_find u_serv (.bits(isr_rank), .base(base), .found(s_found), .line(s_line));

    always_comb begin
        p_rank = p_line - base;
        s_rank = s_line - base;
        hit    = p_found && (!s_found || (p_rank < s_rank));
        line   = p_line;
    end

    always_comb begin
        if (p_found) begin
            AST_PEND_LINE_SET: assert (pend[p_line]) else $error("pending finder line not set"); // R3
        end
        if (s_found) begin
            AST_SERV_LINE_SET: assert (isr_rank[s_line]) else $error("in-service finder line not set"); // R3
        end
    end
endmodule

// File: rtl/irq_capture.sv
module irq_capture
    import irq_core_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  vec_t req,
    input  vec_t trig,
    input  vec_t clr,
    output vec_t irr
);
    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LINES; i++) begin
            if (trig[i]) begin
                st_d.irr[i] = req[i];
            end else if (req[i] && !st_q.last[i]) begin
                st_d.irr[i] = 1'b1;
            end
            st_d.last[i] = req[i];
        end
        st_d.irr = st_d.irr & ~(clr & ~trig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irr = st_q.irr;

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irr & $past(trig)) == ($past(req) & $past(trig))))
        else $error("level line does not follow input"); // R1

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(irr) & ~$past(trig) & ~$past(clr) & ~irr) == '0))
        else $error("edge request dropped without acknowledge"); // R2
endmodule

// File: rtl/irq_core.sv
module irq_core
    import irq_core_pkg::*;
#(
    parameter bit          IS_MASTER = 1'b1,
    parameter int unsigned CASC_LINE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] req_in,
    input  logic [7:0] mask_in,
    input  logic       trig_wr,
    input  logic [7:0] trig_wdata,
    input  logic       nest_en,
    input  logic       auto_eoi_en,
    input  logic       auto_rot_en,
    input  logic       eoi_valid,
    input  logic [1:0] eoi_kind,
    input  logic [2:0] eoi_line,
    input  logic       ack_req,
    output logic       irq_out,
    output logic [2:0] irq_line,
    output logic [2:0] ack_line,
    output logic       ack_none,
    output logic [7:0] irr_out,
    output logic [7:0] isr_out
);
    localparam vec_t  TRIG_KEEP = IS_MASTER ? vec_t'(8'hF8) : vec_t'(8'hDE);
    localparam vec_t  CASC_BIT  = vec_t'(1) << CASC_LINE;
    localparam line_t NO_LINE   = line_t'(LINES - 1);

    core_state_t st_d, st_q;
    vec_t  irr_q, pend, ign, clr, isr_e;
    line_t base_e, tgt, ack_win, eoi_hi_line;
    logic  ack_hit, eoi_hi_found, eoi_do;

    assign pend = irr_q & ~mask_in;
    assign ign  = (IS_MASTER && nest_en) ? CASC_BIT : '0;

    irq_capture u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req_in),
        .trig (st_q.trig),
        .clr  (clr),
        .irr  (irr_q)
    );

    // Resolution of the registered state: drives the request toward the processor
    irq_resolver u_live (
        .pend      (pend),
        .isr       (st_q.isr),
        .isr_ignore(ign),
        .base      (st_q.base),
        .hit       (irq_out),
        .line      (irq_line)
    );

    // Highest in-service line for a non-specific end of interrupt
    irq_rot_find u_eoi (
        .bits (st_q.isr),
        .base (st_q.base),
        .found(eoi_hi_found),
        .line (eoi_hi_line)
    );

    // End of interrupt is applied before the acknowledge looks at the state
    always_comb begin
        isr_e  = st_q.isr;
        base_e = st_q.base;
        tgt    = eoi_kind[EOI_SPEC_BIT] ? eoi_line : eoi_hi_line;
        eoi_do = eoi_valid && (eoi_kind[EOI_SPEC_BIT] || eoi_hi_found);
        if (eoi_do) begin
            isr_e[tgt] = 1'b0;
            if (eoi_kind[EOI_ROT_BIT]) base_e = tgt + line_t'(1);
        end
    end

    // Resolution after the end of interrupt: drives the acknowledge result
    irq_resolver u_ack (
        .pend      (pend),
        .isr       (isr_e),
        .isr_ignore(ign),
        .base      (base_e),
        .hit       (ack_hit),
        .line      (ack_win)
    );

    assign ack_none = !ack_hit;
    assign ack_line = ack_hit ? ack_win : NO_LINE;

    always_comb begin
        st_d      = st_q;
        st_d.isr  = isr_e;
        st_d.base = base_e;
        clr       = '0;
        if (ack_req && ack_hit) begin
            st_d.isr[ack_win] = 1'b1;
            clr[ack_win]      = 1'b1;
            if (auto_eoi_en) begin
                st_d.isr[ack_win] = 1'b0;
                if (auto_rot_en) st_d.base = ack_win + line_t'(1);
            end
        end
        if (trig_wr) st_d.trig = trig_wdata & TRIG_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irr_out = irr_q;
    assign isr_out = st_q.isr;

    AST_ACK_MARKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_none && !auto_eoi_en) |=> isr_out[$past(ack_line)])
        else $error("acknowledged line not in service"); // R6

    AST_AUTO_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_none && auto_eoi_en) |=> !isr_out[$past(ack_line)])
        else $error("automatic end of interrupt left line in service"); // R7

    AST_IRQ_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((irr_out & ~mask_in) != '0))
        else $error("request raised with nothing pending"); // R4

    AST_ONE_NEW_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(isr_out & ~$past(isr_out)) <= 1))
        else $error("more than one line entered service"); // R6

    AST_SPURIOUS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_none |-> (ack_line == NO_LINE))
        else $error("no-winner acknowledge reports a line"); // R6
endmodule

// File: tb/tb_irq_core.sv
module tb_irq_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [7:0] req, mask, trig_wdata;
    logic       trig_wr, nest, aeoi, arot, eoi_valid, ack;
    logic [1:0] eoi_kind;
    logic [2:0] eoi_line;
    logic       irq, ack_none;
    logic [2:0] irq_line, ack_line;
    logic [7:0] irr, isr;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] KEEP = 8'hF8;

    logic [7:0] m_irr, m_last, m_isr, m_trig;
    logic [2:0] m_off;

    irq_core dut (
        .clk(clk), .rst_n(rst_n), .req_in(req), .mask_in(mask),
        .trig_wr(trig_wr), .trig_wdata(trig_wdata), .nest_en(nest),
        .auto_eoi_en(aeoi), .auto_rot_en(arot), .eoi_valid(eoi_valid),
        .eoi_kind(eoi_kind), .eoi_line(eoi_line), .ack_req(ack),
        .irq_out(irq), .irq_line(irq_line), .ack_line(ack_line),
        .ack_none(ack_none), .irr_out(irr), .isr_out(isr)
    );

    function automatic int rank_of(logic [7:0] v, logic [2:0] off);
        for (int k = 0; k < 8; k++) if (v[3'(int'(off) + k)]) return k;
        return 8;
    endfunction

    function automatic int pick(logic [7:0] r, logic [7:0] s, logic [7:0] msk,
                                logic [2:0] off, logic sf);
        logic [7:0] sv = s;
        int p, c;
        if (sf) sv[2] = 1'b0;
        p = rank_of(r & ~msk, off);
        c = rank_of(sv, off);
        if (p < 8 && p < c) return (int'(off) + p) % 8;
        return -1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        trig_wr = 0; eoi_valid = 0; ack = 0; eoi_kind = 0; eoi_line = 0;
    endtask

    task automatic cycle(string tag);
        int live, win, r;
        logic [7:0] isr_e, n_irr;
        logic [2:0] off_e, tgt;
        #1;
        live = pick(m_irr, m_isr, mask, m_off, nest);
        chk(tag, "irq_out", int'(irq), int'(live >= 0));
        if (live >= 0) chk(tag, "irq_line", int'(irq_line), live);
        isr_e = m_isr; off_e = m_off;
        if (eoi_valid) begin
            if (eoi_kind[0]) begin tgt = eoi_line; r = 0; end
            else begin r = rank_of(m_isr, m_off); tgt = 3'(int'(m_off) + r); end
            if (r < 8) begin
                isr_e[tgt] = 1'b0;
                if (eoi_kind[1]) off_e = tgt + 3'd1;
            end
        end
        win = pick(m_irr, isr_e, mask, off_e, nest);
        chk(tag, "ack_none", int'(ack_none), int'(win < 0));
        chk(tag, "ack_line", int'(ack_line), (win < 0) ? 7 : win);
        n_irr = m_irr;
        for (int i = 0; i < 8; i++) begin
            if (m_trig[i]) n_irr[i] = req[i];
            else if (req[i] && !m_last[i]) n_irr[i] = 1'b1;
        end
        m_last = req;
        if (ack && win >= 0) begin
            isr_e[win] = 1'b1;
            if (!m_trig[win]) n_irr[win] = 1'b0;
            if (aeoi) begin
                isr_e[win] = 1'b0;
                if (arot) off_e = 3'(win + 1);
            end
        end
        if (trig_wr) m_trig = trig_wdata & KEEP;
        m_irr = n_irr; m_isr = isr_e; m_off = off_e;
        @(posedge clk); #2;
        chk(tag, "irr_out", int'(irr), int'(m_irr));
        chk(tag, "isr_out", int'(isr), int'(m_isr));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        req = 0; mask = 0; trig_wdata = 0; nest = 0; aeoi = 0; arot = 0;
        idle();
        m_irr = 0; m_last = 0; m_isr = 0; m_trig = 0; m_off = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R11 reset state
        chk("R11", "irr_out", int'(irr), 0);
        chk("R11", "isr_out", int'(isr), 0);
        chk("R11", "irq_out", int'(irq), 0);
        chk("R11", "ack_none", int'(ack_none), 1);

        req = 8'h20; cycle("R2 rising edge");
        req = 8'h00; cycle("R2 kept after input low");
        ack = 1;     cycle("R6 acknowledge line 5");
        ack = 0; req = 8'h40; cycle("R4 lower line blocked");
        req = 8'h42; cycle("R4 higher line preempts");
        ack = 1; cycle("R6 acknowledge line 1");
        ack = 0; eoi_valid = 1; eoi_kind = 2'b00; cycle("R8 non-specific clears line 1");
        eoi_valid = 1; eoi_kind = 2'b00; ack = 1; cycle("R10 EOI before acknowledge");
        idle(); eoi_valid = 1; eoi_kind = 2'b01; eoi_line = 3'd6; cycle("R8 specific line 6");
        idle(); req = 8'h00; trig_wr = 1; trig_wdata = 8'h08; cycle("R9 trigger write");
        idle(); req = 8'h08; cycle("R1 level high");
        ack = 1; cycle("R6 level line not cleared");
        ack = 0; req = 8'h00; cycle("R1 level low");
        eoi_valid = 1; eoi_kind = 2'b01; eoi_line = 3'd3; cycle("R8 specific line 3");
        idle(); trig_wr = 1; trig_wdata = 8'hFF; cycle("R9 low lines forced edge");
        idle(); req = 8'h01; cycle("R9 line 0 edge");
        req = 8'h00; cycle("R9 line 0 kept after low");
        ack = 1; cycle("R9 line 0 edge clear on acknowledge");
        idle(); eoi_valid = 1; eoi_kind = 2'b00; cycle("R8 clear line 0");
        idle(); trig_wr = 1; trig_wdata = 8'h00; cycle("R9 all edge");
        idle(); nest = 1; req = 8'h04; cycle("R5 line 2 request");
        ack = 1; cycle("R5 line 2 in service");
        ack = 0; req = 8'h00; cycle("R5 input low");
        req = 8'h04; cycle("R5 line 2 again");
        cycle("R5 nested line 2 raises request");
        ack = 1; cycle("R5 nested acknowledge");
        idle(); nest = 0; eoi_valid = 1; eoi_kind = 2'b01; eoi_line = 3'd2; cycle("R8 clear line 2");
        idle(); req = 8'h00; aeoi = 1; arot = 1; cycle("R7 modes on");
        req = 8'h10; cycle("R7 line 4 request");
        ack = 1; cycle("R7 auto EOI rotates");
        ack = 0; req = 8'h00; cycle("R3 settle");
        req = 8'h50; cycle("R3 base 5 favours line 6");
        ack = 1; cycle("R3 rotated winner");
        idle(); aeoi = 0; arot = 0; ack = 1; cycle("R6 take line 4");
        idle(); eoi_valid = 1; eoi_kind = 2'b11; eoi_line = 3'd4; cycle("R8 specific rotate");
        idle(); ack = 1; cycle("R6 spurious acknowledge");

        for (int n = 0; n < 4000; n++) begin
            req = 8'($urandom);
            mask = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            trig_wr = (($urandom % 40) == 0);
            trig_wdata = 8'($urandom);
            nest = (($urandom % 3) == 0);
            aeoi = (($urandom % 5) == 0);
            arot = 1'($urandom);
            eoi_valid = (($urandom % 4) == 0);
            eoi_kind = 2'($urandom);
            eoi_line = 3'($urandom);
            ack = (($urandom % 3) == 0);
            cycle("R1 R2 R3 R4 R6 R7 R8 R10 random");
        end
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule